// File: doc/BRIEF.md
# Cache Control Register Unit

This unit holds the programmable state that governs a processor's instruction and data caches. It owns one 32-bit control word and two constant 32-bit configuration words. Software reaches all three over a simple register bus with an address, a write enable, write data, an access size and a read-data return. The unit does not contain the caches. It drives each cache's operating state, a snoop-enable level and one-cycle flush strobes to them, and it takes an interrupt-taken strobe from the core.

Each cache is in one of three states: disabled, frozen or enabled. The control word can ask for a cache to be frozen automatically when the core takes an interrupt. When that happens the unit rewrites its own control word, and no bus access is needed. Some command bits of the control word only trigger an action. They are never stored and always read back as zero.

Top module: `cache_ctl_regs`

## Requirements
- R1: A read with word size (size code 2'b10) returns, in `bus_rdata` on the cycle after the address is presented, the control word at byte offset 0x00, the instruction-cache configuration at 0x04 and the data-cache configuration at 0x08.
- R2: Only word-size accesses act. A write of any other size code (2'b00 byte, 2'b01 half) leaves the control word unchanged, and a read of any other size returns zero.
- R3: Control bits 1:0 carry the instruction-cache state and bits 3:2 carry the data-cache state, using 00 for disabled, 01 for frozen and 11 for enabled. The outputs `icache_state` and `dcache_state` follow the stored fields.
- R4: When `irq_taken` is high, a cache whose state is 11 becomes 01 if its freeze-on-interrupt bit is set. That bit is 4 for the instruction cache and 5 for the data cache.
- R5: The interrupt leaves a cache unchanged if its state is not 11 or if its freeze-on-interrupt bit is clear.
- R6: Bits 14, 15, 16, 21 and 22 of the control word are cleared before a write is stored, so they always read as zero.
- R7: Bit 23 is an ordinary read/write snoop-enable bit, and `snoop_en` follows it.
- R8: The configuration words are read-only. They read 0x10220000 (instruction) and 0x18220000 (data), and writes to them change nothing.
- R9: Reset clears the control word to 0x00000000, so both caches start disabled, and clears `bus_rdata` and both flush strobes.
- R10: A word write to offset 0x00 with bit 21 set pulses `iflush_pulse`, and one with bit 22 set pulses `dflush_pulse`. Each pulse is high for exactly the one cycle after the write.
- R11: Reads of any other offset return zero, and writes to any other offset leave the control word unchanged.
- R12: When a control write and `irq_taken` fall in the same cycle, the freeze rule is applied to the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access size code: 00 byte, 01 half, 10 word |
| bus_rdata | output | 32 | Registered read data |
| irq_taken | input | 1 | One-cycle strobe when the core takes an interrupt |
| icache_state | output | 2 | Instruction-cache state field |
| dcache_state | output | 2 | Data-cache state field |
| snoop_en | output | 1 | Data-cache snoop enable |
| iflush_pulse | output | 1 | Instruction-cache flush strobe |
| dflush_pulse | output | 1 | Data-cache flush strobe |

## Verification
The assertions assume that a read takes place in every cycle, with address and size decoded even when `bus_wr` is high. They also assume that `irq_taken` is a plain level sampled on each edge and needs no handshake. The freeze properties leave out any cycle with a write to offset 0x00, because in that cycle the written value takes priority. The bench changes inputs only on falling edges and holds each access for exactly one rising edge. It raises the interrupt strobe together with a control write only in the scenario that targets that collision.

// File: rtl/cctl_pkg.sv
package cctl_pkg;
  localparam int REG_W   = 32;
  localparam int CACHES  = 2;
  localparam int FRZ_LSB = 4;
  localparam int SNOOP_BIT   = 23;
  localparam int FLUSH_I_BIT = 21;
  localparam int FLUSH_D_BIT = 22;
  // command / status bits that are never stored
  localparam logic [REG_W-1:0] WO_MASK = 32'h0061_C000;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [1:0] {
    CS_OFF    = 2'b00,
    CS_FROZEN = 2'b01,
    CS_ON     = 2'b11
  } cstate_e;
endpackage

// File: rtl/cctl_decode.sv
module cctl_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h00,
  parameter logic [ADDR_W-1:0] ICFG_OFF = 8'h04,
  parameter logic [ADDR_W-1:0] DCFG_OFF = 8'h08
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wr,
  output logic              wr_ctrl,
  output logic              rd_ok,
  output logic              sel_ctrl,
  output logic              sel_icfg,
  output logic              sel_dcfg
);
  import cctl_pkg::*;

  always_comb begin
    rd_ok    = (size == SZ_WORD);
    sel_ctrl = (addr == CTRL_OFF);
    sel_icfg = (addr == ICFG_OFF);
    sel_dcfg = (addr == DCFG_OFF);
    wr_ctrl  = wr && rd_ok && sel_ctrl;
  end
endmodule

// File: rtl/cctl_ctrl_reg.sv
module cctl_ctrl_reg
  import cctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wdata,
  input  logic             irq_taken,
  output logic [REG_W-1:0] ctrl_q,
  output logic             iflush_q,
  output logic             dflush_q
);
  localparam int FLD_W = 2 * CACHES;

  logic [REG_W-1:0]        base;
  logic [CACHES-1:0][1:0]  fld_nxt;
  logic [REG_W-1:0]        ctrl_d;

  assign base = wr_ctrl ? (wdata & ~WO_MASK) : ctrl_q;

  for (genvar g = 0; g < CACHES; g++) begin : g_freeze
    always_comb begin
      fld_nxt[g] = base[2*g +: 2];
      if (irq_taken && base[FRZ_LSB+g] && (base[2*g +: 2] == CS_ON))
        fld_nxt[g] = CS_FROZEN;
    end
  end

  assign ctrl_d = {base[REG_W-1:FLD_W], fld_nxt};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      iflush_q <= 1'b0;
      dflush_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      iflush_q <= wr_ctrl && wdata[FLUSH_I_BIT];
      dflush_q <= wr_ctrl && wdata[FLUSH_D_BIT];
    end
  end
endmodule

// File: rtl/cctl_read_mux.sv
module cctl_read_mux
  import cctl_pkg::*;
#(
  parameter logic [REG_W-1:0] ICFG_VAL = 32'h1022_0000,
  parameter logic [REG_W-1:0] DCFG_VAL = 32'h1822_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_ok,
  input  logic             sel_ctrl,
  input  logic             sel_icfg,
  input  logic             sel_dcfg,
  input  logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] rdata_q
);
  logic [REG_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (rd_ok) begin
      if (sel_ctrl)      rd_d = ctrl_q;
      else if (sel_icfg) rd_d = ICFG_VAL;
      else if (sel_dcfg) rd_d = DCFG_VAL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_d;
  end
endmodule

// File: rtl/cache_ctl_regs.sv
module cache_ctl_regs
  import cctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h00,
  parameter logic [ADDR_W-1:0] ICFG_OFF = 8'h04,
  parameter logic [ADDR_W-1:0] DCFG_OFF = 8'h08,
  parameter logic [REG_W-1:0]  ICFG_VAL = 32'h1022_0000,
  parameter logic [REG_W-1:0]  DCFG_VAL = 32'h1822_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [1:0]        bus_size,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              irq_taken,
  output logic [1:0]        icache_state,
  output logic [1:0]        dcache_state,
  output logic              snoop_en,
  output logic              iflush_pulse,
  output logic              dflush_pulse
);
  logic wr_ctrl, rd_ok, sel_ctrl, sel_icfg, sel_dcfg;
  logic [REG_W-1:0] ctrl_q;

  cctl_decode #(
    .ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .ICFG_OFF(ICFG_OFF), .DCFG_OFF(DCFG_OFF)
  ) u_dec (
    .addr(bus_addr), .size(bus_size), .wr(bus_wr),
    .wr_ctrl(wr_ctrl), .rd_ok(rd_ok),
    .sel_ctrl(sel_ctrl), .sel_icfg(sel_icfg), .sel_dcfg(sel_dcfg)
  );

  cctl_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
    .irq_taken(irq_taken), .ctrl_q(ctrl_q),
    .iflush_q(iflush_pulse), .dflush_q(dflush_pulse)
  );

  cctl_read_mux #(.ICFG_VAL(ICFG_VAL), .DCFG_VAL(DCFG_VAL)) u_rd (
    .clk(clk), .rst(rst), .rd_ok(rd_ok),
    .sel_ctrl(sel_ctrl), .sel_icfg(sel_icfg), .sel_dcfg(sel_dcfg),
    .ctrl_q(ctrl_q), .rdata_q(bus_rdata)
  );

  assign icache_state = ctrl_q[1:0];
  assign dcache_state = ctrl_q[3:2];
  assign snoop_en     = ctrl_q[SNOOP_BIT];
endmodule

// File: rtl/cctl_checker.sv
module cctl_checker
  import cctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h00,
  parameter logic [ADDR_W-1:0] ICFG_OFF = 8'h04,
  parameter logic [ADDR_W-1:0] DCFG_OFF = 8'h08,
  parameter logic [REG_W-1:0]  ICFG_VAL = 32'h1022_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [1:0]        bus_size,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              irq_taken,
  input logic [REG_W-1:0]  ctrl_q,
  input logic [1:0]        icache_state,
  input logic              iflush_pulse
);
  logic ctrl_touch;
  logic unmapped;
  assign ctrl_touch = bus_wr && (bus_addr == CTRL_OFF);
  assign unmapped   = (bus_addr != CTRL_OFF) && (bus_addr != ICFG_OFF) && (bus_addr != DCFG_OFF);

  AST_SMALL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_size != SZ_WORD && !irq_taken) |=> $stable(ctrl_q)); // R2
  AST_SMALL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_size != SZ_WORD) |=> (bus_rdata == '0)); // R2
  AST_ICACHE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (irq_taken && !ctrl_touch && ctrl_q[FRZ_LSB] && ctrl_q[1:0] == 2'b11) |=> (icache_state == 2'b01)); // R4
  AST_NO_FREEZE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (irq_taken && !ctrl_touch && ctrl_q[1:0] != 2'b11) |=> $stable(icache_state)); // R5
  AST_WO_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_size == SZ_WORD && bus_addr == CTRL_OFF) |=> ((ctrl_q & WO_MASK) == '0)); // R6
  AST_ICFG_CONST: assert property (@(posedge clk) disable iff (rst)
    (bus_size == SZ_WORD && bus_addr == ICFG_OFF) |=> (bus_rdata == ICFG_VAL)); // R8
  AST_IFLUSH_SOURCE: assert property (@(posedge clk) disable iff (rst)
    iflush_pulse |-> $past(bus_wr && bus_size == SZ_WORD && bus_addr == CTRL_OFF && bus_wdata[FLUSH_I_BIT])); // R10
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_size == SZ_WORD && unmapped) |=> (bus_rdata == '0)); // R11
endmodule

bind cache_ctl_regs cctl_checker #(
  .ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .ICFG_OFF(ICFG_OFF),
  .DCFG_OFF(DCFG_OFF), .ICFG_VAL(ICFG_VAL)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_rdata(bus_rdata),
  .irq_taken(irq_taken), .ctrl_q(ctrl_q), .icache_state(icache_state),
  .iflush_pulse(iflush_pulse)
);

// File: tb/test_cache_ctl_regs.sv
`timescale 1ns/1ps
module test_cache_ctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] W = 2'b10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_size = W;
  logic [31:0] bus_rdata;
  logic        irq_taken = 1'b0;
  logic [1:0]  icache_state, dcache_state;
  logic        snoop_en, iflush_pulse, dflush_pulse;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_ctl_regs i_cache_ctl_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_rdata(bus_rdata),
    .irq_taken(irq_taken), .icache_state(icache_state),
    .dcache_state(dcache_state), .snoop_en(snoop_en),
    .iflush_pulse(iflush_pulse), .dflush_pulse(dflush_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one-edge access; returns at the falling edge after the capturing edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s, input logic irq);
    bus_addr = a; bus_wdata = d; bus_size = s; bus_wr = 1'b1; irq_taken = irq;
    @(negedge clk);
    bus_wr = 1'b0; irq_taken = 1'b0; bus_size = W;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
    bus_addr = a; bus_size = s; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
    bus_size = W;
  endtask

  task automatic irq_only();
    irq_taken = 1'b1;
    @(negedge clk);
    irq_taken = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 rdata after reset", bus_rdata, 32'h0);
    chk("R9 flush strobes idle", {30'd0, iflush_pulse, dflush_pulse}, 32'h0);
    chk("R9 cache states disabled", {28'd0, dcache_state, icache_state}, 32'h0);
    rd(8'h00, W, d); chk("R9 R1 control reads zero", d, 32'h0);
    rd(8'h04, W, d); chk("R8 R1 icache config", d, 32'h1022_0000);
    rd(8'h08, W, d); chk("R8 R1 dcache config", d, 32'h1822_0000);
  endtask

  task automatic t_freeze();
    logic [31:0] d;
    wr(8'h00, 32'h0000_003F, W, 1'b0);
    chk("R3 icache enabled", {30'd0, icache_state}, 32'h3);
    chk("R3 dcache enabled", {30'd0, dcache_state}, 32'h3);
    rd(8'h00, W, d); chk("R1 control readback", d, 32'h3F);
    irq_only();
    rd(8'h00, W, d); chk("R4 both caches frozen", d, 32'h35);
    irq_only();
    rd(8'h00, W, d); chk("R5 frozen stays frozen", d, 32'h35);
    wr(8'h00, 32'h0000_000F, W, 1'b0);
    irq_only();
    rd(8'h00, W, d); chk("R5 freeze bits clear, no change", d, 32'h0F);
    wr(8'h00, 32'h0000_003C, W, 1'b0);
    irq_only();
    rd(8'h00, W, d); chk("R5 R4 disabled icache kept, dcache frozen", d, 32'h34);
  endtask

  task automatic t_write_only();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF, W, 1'b0);
    chk("R10 both flush strobes high", {30'd0, iflush_pulse, dflush_pulse}, 32'h3);
    chk("R7 snoop enabled", {31'd0, snoop_en}, 32'h1);
    rd(8'h00, W, d);
    chk("R10 flush strobes one cycle", {30'd0, iflush_pulse, dflush_pulse}, 32'h0);
    chk("R6 write-only bits read zero", d, 32'hFF9E_3FFF);
    wr(8'h00, 32'h0020_0000, W, 1'b0);
    chk("R10 instruction flush only", {30'd0, iflush_pulse, dflush_pulse}, 32'h2);
    wr(8'h00, 32'h0080_0000, W, 1'b0);
    chk("R7 snoop only", {31'd0, snoop_en}, 32'h1);
    rd(8'h00, W, d); chk("R7 snoop bit stored", d, 32'h0080_0000);
  endtask

  task automatic t_size();
    logic [31:0] d;
    wr(8'h00, 32'h0040_0003, 2'b01, 1'b0);
    chk("R2 half write gives no flush", {31'd0, dflush_pulse}, 32'h0);
    wr(8'h00, 32'h0000_0003, 2'b00, 1'b0);
    rd(8'h00, W, d); chk("R2 narrow writes ignored", d, 32'h0080_0000);
    rd(8'h00, 2'b00, d); chk("R2 byte read zero", d, 32'h0);
    rd(8'h04, 2'b01, d); chk("R2 half read zero", d, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(8'h04, 32'h0000_0000, W, 1'b0);
    wr(8'h08, 32'hFFFF_FFFF, W, 1'b0);
    rd(8'h04, W, d); chk("R8 icache config unwritable", d, 32'h1022_0000);
    rd(8'h08, W, d); chk("R8 dcache config unwritable", d, 32'h1822_0000);
    wr(8'h0C, 32'h0000_000F, W, 1'b0);
    wr(8'h01, 32'h0000_000F, W, 1'b0);
    rd(8'h00, W, d); chk("R11 stray writes ignored", d, 32'h0080_0000);
    rd(8'h0C, W, d); chk("R11 unmapped read zero", d, 32'h0);
    rd(8'h10, W, d); chk("R11 unmapped read zero high", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(8'h00, 32'h0000_0013, W, 1'b1);
    rd(8'h00, W, d); chk("R12 freeze applied to written value", d, 32'h11);
    wr(8'h00, 32'h0000_002F, W, 1'b1);
    rd(8'h00, W, d); chk("R12 only data cache frozen", d, 32'h27);
    wr(8'h00, 32'h0000_0003, W, 1'b1);
    rd(8'h00, W, d); chk("R12 no freeze bit, stays enabled", d, 32'h03);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_freeze();
    t_write_only();
    t_size();
    t_map();
    t_collide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule